// File: doc/BRIEF.md
# Five-Stage Multicycle Instruction Controller

This block sequences a small 32-bit load/store machine through five fixed stages for every instruction: fetch, decode with register read, ALU, memory access and register write-back. It holds the program counter, the instruction register, a general-purpose register file and the inter-stage operand latches. From the opcode and function fields of the latched instruction it raises the per-stage enables that steer the PC, the two register read ports, the ALU, the data memory port and the register write port.

Four operations are decoded: register add, set-less-than against a signed immediate, word load and word store. Each one spends exactly five cycles in the controller. A stage an operation has no use for is still visited as an idle cycle, so instruction timing never depends on the opcode. Instruction memory is read at the PC during fetch. Data memory is read or written during the memory stage. Both memories sit outside the block and answer combinationally.

Top module: `mcc_ctrl`

## Requirements
- R1: While reset is held, `stage_o` is 5'b00001 (fetch), `imem_addr_o` is 0, and `dmem_re_o`, `dmem_we_o` and `rf_we_o` are low. Every general-purpose register is cleared.
- R2: `stage_o` is one-hot and walks bit 0 (fetch), bit 1 (decode), bit 2 (ALU), bit 3 (memory), bit 4 (write-back), then returns to bit 0. Every instruction, supported or not, takes exactly five cycles.
- R3: `imem_addr_o` equals the PC. `pc_we_o` is high only in fetch, and the PC then advances by 4 at the end of that cycle. In all other stages the PC holds.
- R4: Encodings are as follows. add: opcode 6'h00, shamt 0, funct 6'h20, written rd = rs + rt. slti: opcode 6'h0A. lw: opcode 6'h23. sw: opcode 6'h2B. For the I-type encodings, rs is bits 25:21, rt is bits 20:16 and imm is bits 15:0. In decode, `rf_rd_a_o` is high for all four, and `rf_rd_b_o` is high only for add and sw.
- R5: `alu_en_o` is high in the ALU stage for the four supported operations and at no other time. For add, write-back stores the 32-bit wrapping sum of rs and rt into rd.
- R6: For lw and sw, `dmem_addr_o` in the memory stage equals the rs value plus the sign-extended 16-bit immediate, modulo 2^32.
- R7: In the memory stage, `dmem_re_o` is high only for lw and `dmem_we_o` is high only for sw. For sw, `dmem_wdata_o` carries the rt value. All other stages, and all other operations, leave both low.
- R8: `rf_we_o` is high only in write-back and only for add, slti and lw, with `rf_waddr_o` being rd for add and rt otherwise. For lw, `rf_wdata_o` is the word returned on `dmem_rdata_i` during the memory stage. sw writes no register.
- R9: slti writes 1 to rt when rs is less than the sign-extended immediate in two's-complement order, and 0 otherwise.
- R10: Register 0 reads as zero and keeps no value written to it.
- R11: Any other opcode, an opcode-0 funct other than 6'h20, or an add encoding with nonzero shamt raises no read, ALU, memory or register-write enable. It changes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_o | output | 5 | One-hot current stage |
| imem_addr_o | output | 32 | Instruction memory byte address (PC) |
| imem_rdata_i | input | 32 | Instruction word at `imem_addr_o` |
| pc_we_o | output | 1 | PC update enable (fetch) |
| rf_rd_a_o | output | 1 | Register read port A enable (rs) |
| rf_rd_b_o | output | 1 | Register read port B enable (rt) |
| alu_en_o | output | 1 | ALU result capture enable |
| dmem_addr_o | output | 32 | Data memory byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data for `dmem_addr_o` |
| dmem_re_o | output | 1 | Data memory read strobe |
| dmem_we_o | output | 1 | Data memory write strobe |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write value |

## Verification
A fault in the stage sequencer shows up within one cycle. The one-hot stage vector and the enable pattern both depart from the fixed five-step walk, and the PC is sampled against its own count at every fetch. A corrupted register, operand latch or ALU result stays invisible until it is consumed. Stored data is therefore compared on every sw and write-back values on every write, so a bad value surfaces at the next write-back or store that reads it. Sweeps of add and slti over a set of edge operands, including sign boundaries and the most negative immediate, put each arithmetic path on the ports within ten cycles of its computation.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
   localparam int NUM_STAGES = 5;
   localparam int STG_FETCH  = 0;
   localparam int STG_DECODE = 1;
   localparam int STG_EXEC   = 2;
   localparam int STG_MEM    = 3;
   localparam int STG_WB     = 4;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_SLTI  = 6'h0A;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] FN_ADD    = 6'h20;

   typedef enum logic [2:0] {
      K_NONE, K_ADD, K_SLTI, K_LOAD, K_STORE
   } kind_e;

   typedef struct packed {
      logic rd_a;
      logic rd_b;
      logic use_alu;
      logic mem_rd;
      logic mem_wr;
      logic reg_wr;
      logic dst_is_rd;
   } ctl_t;
endpackage

// File: rtl/mcc_stage_seq.sv
`timescale 1ns/1ps
module mcc_stage_seq
   import mcc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [NUM_STAGES-1:0] stage_oh
);
   localparam int CNT_W = $clog2(NUM_STAGES);

   generate
      if (ONE_HOT) begin : g_ring
         logic [NUM_STAGES-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q <= NUM_STAGES'(1);
            else        ring_q <= {ring_q[NUM_STAGES-2:0], ring_q[NUM_STAGES-1]};
         end
         assign stage_oh = ring_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cnt_q <= '0;
            else if (cnt_q == CNT_W'(NUM_STAGES - 1))  cnt_q <= '0;
            else                                       cnt_q <= cnt_q + CNT_W'(1);
         end
         always_comb begin
            for (int i = 0; i < NUM_STAGES; i++) stage_oh[i] = (cnt_q == CNT_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/mcc_decode.sv
`timescale 1ns/1ps
module mcc_decode
   import mcc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [31:0]       instr,
   output kind_e             kind,
   output ctl_t              ctl,
   output logic [4:0]        rs,
   output logic [4:0]        rt,
   output logic [4:0]        rd,
   output logic [DATA_W-1:0] imm_sx
);
   logic [5:0] opc, fn;
   logic [4:0] sh;

   assign opc    = instr[31:26];
   assign rs     = instr[25:21];
   assign rt     = instr[20:16];
   assign rd     = instr[15:11];
   assign sh     = instr[10:6];
   assign fn     = instr[5:0];
   assign imm_sx = {{(DATA_W-16){instr[15]}}, instr[15:0]};

   always_comb begin
      kind = K_NONE;
      ctl  = '0;
      case (opc)
         OPC_RTYPE: if (fn == FN_ADD && sh == 5'd0) begin
            kind          = K_ADD;
            ctl.rd_a      = 1'b1;
            ctl.rd_b      = 1'b1;
            ctl.use_alu   = 1'b1;
            ctl.reg_wr    = 1'b1;
            ctl.dst_is_rd = 1'b1;
         end
         OPC_SLTI: begin
            kind        = K_SLTI;
            ctl.rd_a    = 1'b1;
            ctl.use_alu = 1'b1;
            ctl.reg_wr  = 1'b1;
         end
         OPC_LOAD: begin
            kind        = K_LOAD;
            ctl.rd_a    = 1'b1;
            ctl.use_alu = 1'b1;
            ctl.mem_rd  = 1'b1;
            ctl.reg_wr  = 1'b1;
         end
         OPC_STORE: begin
            kind        = K_STORE;
            ctl.rd_a    = 1'b1;
            ctl.rd_b    = 1'b1;
            ctl.use_alu = 1'b1;
            ctl.mem_wr  = 1'b1;
         end
         default: begin
            kind = K_NONE;
            ctl  = '0;
         end
      endcase
   end
endmodule

// File: rtl/mcc_regfile.sv
`timescale 1ns/1ps
module mcc_regfile #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] rb_data,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [DATA_W-1:0] wd
);
   logic [NUM_REGS-1:0][DATA_W-1:0] bank;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign bank[g] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                        q <= '0;
               else if (we && wa == AW'(g))       q <= wd;
            end
            assign bank[g] = q;
         end
      end
   endgenerate

   assign ra_data = bank[ra_addr];
   assign rb_data = bank[rb_addr];
endmodule

// File: rtl/mcc_alu.sv
`timescale 1ns/1ps
module mcc_alu
   import mcc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit SLT_VIA_SUB = 1'b1
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] y
);
   logic lt;

   generate
      if (SLT_VIA_SUB) begin : g_slt_sub
         logic [DATA_W-1:0] diff;
         assign diff = a - imm;
         assign lt = (a[DATA_W-1] != imm[DATA_W-1]) ? a[DATA_W-1]
                                                    : ((diff >> (DATA_W-1)) != '0);
      end else begin : g_slt_cmp
         assign lt = $signed(a) < $signed(imm);
      end
   endgenerate

   always_comb begin
      case (kind)
         K_ADD:            y = a + b;
         K_SLTI:           y = {{(DATA_W-1){1'b0}}, lt};
         K_LOAD, K_STORE:  y = a + imm;
         default:          y = '0;
      endcase
   end
endmodule

// File: rtl/mcc_ctrl.sv
`timescale 1ns/1ps
module mcc_ctrl
   import mcc_pkg::*;
#(
   parameter int          DATA_W        = 32,
   parameter int          NUM_REGS      = 32,
   parameter int unsigned RESET_PC      = 0,
   parameter bit          ONE_HOT_STAGE = 1'b1,
   parameter bit          SLT_VIA_SUB   = 1'b1,
   localparam int         RA_W          = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [NUM_STAGES-1:0] stage_o,
   output logic [DATA_W-1:0]     imem_addr_o,
   input  logic [31:0]           imem_rdata_i,
   output logic                  pc_we_o,
   output logic                  rf_rd_a_o,
   output logic                  rf_rd_b_o,
   output logic                  alu_en_o,
   output logic [DATA_W-1:0]     dmem_addr_o,
   output logic [DATA_W-1:0]     dmem_wdata_o,
   input  logic [DATA_W-1:0]     dmem_rdata_i,
   output logic                  dmem_re_o,
   output logic                  dmem_we_o,
   output logic                  rf_we_o,
   output logic [RA_W-1:0]       rf_waddr_o,
   output logic [DATA_W-1:0]     rf_wdata_o
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("mcc_ctrl: DATA_W must be 32 to match the instruction format");
      end
      if (NUM_REGS < 2 || NUM_REGS > 32 || (1 << RA_W) != NUM_REGS) begin : g_bad_regs
         $error("mcc_ctrl: NUM_REGS must be a power of two from 2 to 32");
      end
      if (RESET_PC % 4 != 0) begin : g_bad_pc
         $error("mcc_ctrl: RESET_PC must be word aligned");
      end
   endgenerate

   logic [NUM_STAGES-1:0] stage;
   logic                  in_fetch, in_dec, in_exe, in_mem, in_wb;
   logic [DATA_W-1:0]     pc_q, a_q, b_q, alu_q, mdr_q;
   logic [31:0]           ir_q;
   kind_e                 kind;
   ctl_t                  ctl;
   logic [4:0]            rs, rt, rd;
   logic [DATA_W-1:0]     imm_sx, ra_data, rb_data, alu_y;
   logic                  wr_en;
   logic [RA_W-1:0]       wr_idx;
   logic [DATA_W-1:0]     wr_val;

   mcc_stage_seq #(.ONE_HOT(ONE_HOT_STAGE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_oh (stage)
   );

   assign in_fetch = stage[STG_FETCH];
   assign in_dec   = stage[STG_DECODE];
   assign in_exe   = stage[STG_EXEC];
   assign in_mem   = stage[STG_MEM];
   assign in_wb    = stage[STG_WB];

   mcc_decode #(.DATA_W(DATA_W)) u_dec (
      .instr  (ir_q),
      .kind   (kind),
      .ctl    (ctl),
      .rs     (rs),
      .rt     (rt),
      .rd     (rd),
      .imm_sx (imm_sx)
   );

   assign wr_en  = in_wb & ctl.reg_wr;
   assign wr_idx = ctl.dst_is_rd ? rd[RA_W-1:0] : rt[RA_W-1:0];
   assign wr_val = ctl.mem_rd ? mdr_q : alu_q;

   mcc_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (rs[RA_W-1:0]),
      .ra_data (ra_data),
      .rb_addr (rt[RA_W-1:0]),
      .rb_data (rb_data),
      .we      (wr_en),
      .wa      (wr_idx),
      .wd      (wr_val)
   );

   mcc_alu #(.DATA_W(DATA_W), .SLT_VIA_SUB(SLT_VIA_SUB)) u_alu (
      .kind (kind),
      .a    (a_q),
      .b    (b_q),
      .imm  (imm_sx),
      .y    (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= DATA_W'(RESET_PC);
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
         mdr_q <= '0;
      end else begin
         if (in_fetch) begin
            ir_q <= imem_rdata_i;
            pc_q <= pc_q + DATA_W'(4);
         end
         if (in_dec && ctl.rd_a)      a_q   <= ra_data;
         if (in_dec && ctl.rd_b)      b_q   <= rb_data;
         if (in_exe && ctl.use_alu)   alu_q <= alu_y;
         if (in_mem && ctl.mem_rd)    mdr_q <= dmem_rdata_i;
      end
   end

   assign stage_o      = stage;
   assign imem_addr_o  = pc_q;
   assign pc_we_o      = in_fetch;
   assign rf_rd_a_o    = in_dec & ctl.rd_a;
   assign rf_rd_b_o    = in_dec & ctl.rd_b;
   assign alu_en_o     = in_exe & ctl.use_alu;
   assign dmem_addr_o  = alu_q;
   assign dmem_wdata_o = b_q;
   assign dmem_re_o    = in_mem & ctl.mem_rd;
   assign dmem_we_o    = in_mem & ctl.mem_wr;
   assign rf_we_o      = wr_en;
   assign rf_waddr_o   = wr_idx;
   assign rf_wdata_o   = wr_val;
endmodule

// File: rtl/mcc_ctrl_chk.sv
`timescale 1ns/1ps
module mcc_ctrl_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        stage_o,
   input logic [DATA_W-1:0] imem_addr_o,
   input logic              pc_we_o,
   input logic              rf_rd_a_o,
   input logic              rf_rd_b_o,
   input logic              alu_en_o,
   input logic              dmem_re_o,
   input logic              dmem_we_o,
   input logic              rf_we_o
);
   assert_stage_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stage_o) == 1);

   assert_stage_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stage_o[4] |=> stage_o[0]);

   assert_stage_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stage_o[0] |=> stage_o[1]);

   assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we_o |=> imem_addr_o == $past(imem_addr_o) + DATA_W'(4));

   assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_we_o |=> $stable(imem_addr_o));

   assert_pc_we_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we_o |-> stage_o[0]);

   assert_read_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_rd_a_o || rf_rd_b_o) |-> stage_o[1]);

   assert_alu_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alu_en_o |-> stage_o[2]);

   assert_mem_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_re_o || dmem_we_o) |-> (stage_o[3] && !(dmem_re_o && dmem_we_o)));

   assert_rf_we_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> stage_o[4]);
endmodule

bind mcc_ctrl mcc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stage_o     (stage_o),
   .imem_addr_o (imem_addr_o),
   .pc_we_o     (pc_we_o),
   .rf_rd_a_o   (rf_rd_a_o),
   .rf_rd_b_o   (rf_rd_b_o),
   .alu_en_o    (alu_en_o),
   .dmem_re_o   (dmem_re_o),
   .dmem_we_o   (dmem_we_o),
   .rf_we_o     (rf_we_o)
);

// File: tb/mcc_ctrl_tb.sv
`timescale 1ns/1ps
module mcc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  stage_o;
   logic [31:0] imem_addr_o, cur_instr;
   logic        pc_we_o, rf_rd_a_o, rf_rd_b_o, alu_en_o;
   logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
   logic        dmem_re_o, dmem_we_o, rf_we_o;
   logic [4:0]  rf_waddr_o;
   logic [31:0] rf_wdata_o;
   logic [6:0]  ctl_vec;

   logic [31:0] dmem_m [256];
   logic [31:0] regs_m [32];
   logic [31:0] exp_pc;
   int          checks = 0;
   int          errors = 0;
   string       ctx = "";

   always #2 clk = ~clk;

   mcc_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .stage_o      (stage_o),
      .imem_addr_o  (imem_addr_o),
      .imem_rdata_i (cur_instr),
      .pc_we_o      (pc_we_o),
      .rf_rd_a_o    (rf_rd_a_o),
      .rf_rd_b_o    (rf_rd_b_o),
      .alu_en_o     (alu_en_o),
      .dmem_addr_o  (dmem_addr_o),
      .dmem_wdata_o (dmem_wdata_o),
      .dmem_rdata_i (dmem_rdata_i),
      .dmem_re_o    (dmem_re_o),
      .dmem_we_o    (dmem_we_o),
      .rf_we_o      (rf_we_o),
      .rf_waddr_o   (rf_waddr_o),
      .rf_wdata_o   (rf_wdata_o)
   );

   assign dmem_rdata_i = dmem_m[dmem_addr_o[9:2]];
   assign ctl_vec = {pc_we_o, rf_rd_a_o, rf_rd_b_o, alu_en_o, dmem_re_o, dmem_we_o, rf_we_o};

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s: actual %h expected %h", req, ctx, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt,
                                         input int sh, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                         input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Runs one instruction from its fetch cycle to the next fetch cycle.
   task automatic run_instr(input logic [31:0] ins);
      logic [5:0]  opc  = ins[31:26];
      int          rs   = int'(ins[25:21]);
      int          rt   = int'(ins[20:16]);
      int          rd   = int'(ins[15:11]);
      logic [31:0] sx   = {{16{ins[15]}}, ins[15:0]};
      bit          is_add  = (opc == 6'h00) && (ins[5:0] == 6'h20) && (ins[10:6] == 5'd0);
      bit          is_slti = (opc == 6'h0A);
      bit          is_lw   = (opc == 6'h23);
      bit          is_sw   = (opc == 6'h2B);
      bit          sup     = is_add | is_slti | is_lw | is_sw;
      bit          wr      = is_add | is_slti | is_lw;
      logic [31:0] addr    = regs_m[rs] + sx;
      logic [31:0] wval    = 32'd0;
      int          dst     = is_add ? rd : rt;
      cur_instr = ins;
      // fetch
      chk("R2", "stage fetch", 32'(stage_o), 32'h01);
      chk("R3", "pc at fetch", imem_addr_o, exp_pc);
      chk("R3", "fetch enables", 32'(ctl_vec), 32'h40);
      step();
      // decode
      exp_pc = exp_pc + 32'd4;
      chk("R2", "stage decode", 32'(stage_o), 32'h02);
      chk("R3", "pc advanced", imem_addr_o, exp_pc);
      chk("R4", "decode enables", 32'(ctl_vec), 32'({1'b0, sup, is_add | is_sw, 4'b0}));
      step();
      // ALU
      chk("R2", "stage alu", 32'(stage_o), 32'h04);
      chk("R5", "alu enables", 32'(ctl_vec), 32'({3'b0, sup, 3'b0}));
      step();
      // memory
      chk("R2", "stage mem", 32'(stage_o), 32'h08);
      chk("R7", "mem enables", 32'(ctl_vec), 32'({4'b0, is_lw, is_sw, 1'b0}));
      if (is_lw || is_sw) chk("R6", "data address", dmem_addr_o, addr);
      if (is_sw) begin
         chk("R7", "store data", dmem_wdata_o, regs_m[rt]);
         dmem_m[addr[9:2]] = regs_m[rt];
      end
      if (is_add)  wval = regs_m[rs] + regs_m[rt];
      if (is_slti) wval = ($signed(regs_m[rs]) < $signed(sx)) ? 32'd1 : 32'd0;
      if (is_lw)   wval = dmem_m[addr[9:2]];
      step();
      // write-back
      chk("R2", "stage wb", 32'(stage_o), 32'h10);
      chk("R8", "wb enables", 32'(ctl_vec), 32'({6'b0, wr}));
      if (wr) begin
         chk("R8", "write index", 32'(rf_waddr_o), 32'(dst));
         chk(is_slti ? "R9" : (is_add ? "R5" : "R8"), "write value", rf_wdata_o, wval);
         if (dst != 0) regs_m[dst] = wval;
      end
      step();
   endtask

   initial begin
      logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0011, 16'h7FFF, 16'h8000};
      logic [31:0] seeds [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h11,
                                 32'h7FFF_FFFF, 32'h8000_0000, 32'h10, 32'h1234_5678};
      for (int i = 0; i < 256; i++) dmem_m[i] = 32'hC0DE_0000 | 32'(i);
      for (int i = 0; i < 8; i++)   dmem_m[i] = seeds[i];
      dmem_m[16] = 32'h100;
      for (int i = 0; i < 32; i++)  regs_m[i] = 32'd0;
      exp_pc    = 32'd0;
      cur_instr = 32'd0;
      rst_n     = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      ctx = "R1 reset";
      chk("R1", "stage in reset", 32'(stage_o), 32'h01);
      chk("R1", "pc in reset", imem_addr_o, 32'd0);
      chk("R1", "write strobes in reset", 32'({dmem_re_o, dmem_we_o, rf_we_o}), 32'd0);
      rst_n = 1'b1;

      ctx = "R1 cleared registers";
      run_instr(enc_i(6'h2B, 0, 1, 16'h0200));
      run_instr(enc_i(6'h2B, 0, 7, 16'h0200));
      run_instr(enc_i(6'h2B, 0, 31, 16'h0200));

      ctx = "R8 loads";
      for (int i = 1; i <= 8; i++) run_instr(enc_i(6'h23, 0, i, 16'((i - 1) * 4)));
      run_instr(enc_i(6'h23, 0, 20, 16'h0040));

      ctx = "R5 add sweep";
      for (int i = 1; i <= 8; i++)
         for (int j = 1; j <= 8; j++) begin
            run_instr(enc_r(9, i, j, 0, 6'h20));
            run_instr(enc_i(6'h2B, 0, 9, 16'h0204));
         end

      ctx = "R9 slti sweep";
      for (int i = 1; i <= 8; i++)
         for (int k = 0; k < 6; k++) begin
            run_instr(enc_i(6'h0A, i, 10, imms[k]));
            run_instr(enc_i(6'h2B, 0, 10, 16'h0208));
         end

      ctx = "R6 negative offset";
      run_instr(enc_i(6'h2B, 20, 4, 16'hFFFC));
      run_instr(enc_i(6'h23, 20, 11, 16'hFFFC));
      run_instr(enc_i(6'h2B, 20, 11, 16'h0008));

      ctx = "R10 zero register";
      run_instr(enc_r(0, 2, 8, 0, 6'h20));
      run_instr(enc_i(6'h2B, 0, 0, 16'h020C));
      run_instr(enc_i(6'h23, 0, 0, 16'h0004));
      run_instr(enc_i(6'h0A, 0, 0, 16'h0005));
      run_instr(enc_i(6'h2B, 0, 0, 16'h020C));
      run_instr(enc_r(12, 0, 0, 0, 6'h20));
      run_instr(enc_i(6'h2B, 0, 12, 16'h0210));

      ctx = "R11 unsupported";
      run_instr(enc_i(6'h23, 0, 12, 16'h001C));
      run_instr(enc_i(6'h3F, 1, 12, 16'h0004));
      run_instr(enc_r(12, 2, 3, 0, 6'h22));
      run_instr(enc_r(12, 2, 3, 1, 6'h20));
      run_instr(enc_i(6'h08, 2, 12, 16'h0004));
      run_instr(enc_i(6'h2B, 0, 12, 16'h0210));
      chk("R11", "memory untouched by unsupported ops", dmem_m[1], 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule